// File: doc/BRIEF.md
# LCD Pixel Clock and Frame-Synchronised Control

This block is the clocking and control register group of a simple LCD panel interface. Software writes three byte-wide registers over a small synchronous bus. One register sets the pixel clock division ratio, one sets the toggle rate of the alternating-drive signal, and one holds the controller enable, the DMA burst length, the clock source select and some spare control bits. The DMA engine, the line buffer and the panel data path sit outside this block.

The pixel clock is not a separate clock. The block gives a one-cycle pixel enable, `pix_en`. It counts the strobes of the selected source tick (`pll_tick` or `alt_tick`) and pulses once for every N of them, where N is the divider field plus one. A field value of zero is bypass mode: every selected tick passes straight through. The alternating-drive output `acd` inverts after a programmable number of first-line-marker pulses (`flm_pulse`). The controller enable, whether set or cleared, takes effect only on an FLM pulse. A new divider or rate value written while the block runs is used from the next wrap of its counter.

Top module: `lcd_clk_ctrl`

## Requirements
- R1: After synchronous reset, all three registers read 0x00, and `pix_en`, `acd`, `lcd_active` and `burst16` are 0.
- R2: A write with `bus_we` high updates the register addressed by `bus_addr`: 0x23 holds the 4-bit rate field in bits 3:0, 0x25 holds the 6-bit divider field in bits 5:0, and 0x27 holds the 8-bit control byte. `bus_rdata` returns the addressed register combinationally. Unused upper bits read as zero. Any other address reads 0x00, and a write to it changes no register.
- R3: While active with divider field D > 0, `pix_en` pulses for one cycle on every (D+1)-th selected tick, counting from the first tick after activation.
- R4: While active with divider field 0, `pix_en` equals the selected tick in every cycle.
- R5: Control bit 0 chooses the divider source: 0 uses `pll_tick`, 1 uses `alt_tick`. The other tick has no effect.
- R6: While active, `acd` inverts once every (R+1) FLM pulses, where R is the 4-bit rate field. It changes only on the clock edge that samples an FLM pulse.
- R7: `lcd_active` loads control bit 7 only on a clock edge where `flm_pulse` is high. Setting or clearing bit 7 at any other time leaves it unchanged.
- R8: While `lcd_active` is 0, `pix_en` is 0 and the divider and ACD counters are held at zero. From the second inactive cycle on, `acd` is 0.
- R9: `burst16` follows control bit 6 (1 = 16-word bursts, 0 = 8-word bursts), from the cycle after the write.
- R10: A divider or rate value written while active is used only from the next wrap of its counter. The period in progress finishes with the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| pll_tick | input | 1 | Source tick 0 (PLL-derived) |
| alt_tick | input | 1 | Source tick 1 (alternate) |
| flm_pulse | input | 1 | First-line-marker strobe, one cycle per frame |
| pix_en | output | 1 | Pixel clock enable, one cycle per pixel |
| acd | output | 1 | Alternating-drive signal |
| lcd_active | output | 1 | Controller enable, qualified at FLM |
| burst16 | output | 1 | DMA burst length: 1 = 16 words, 0 = 8 words |

## Verification
The checker assumes `flm_pulse` and the tick inputs are synchronous to `clk` and are sampled only at rising edges. It also assumes reset is asserted from time zero, so the history-based properties never see pre-reset values. The bench changes every input on the falling edge and holds it for a full cycle. It sends FLM only as single strobes at a fixed spacing and uses register writes as the only way to change the configuration, so every input the properties rely on stays within these limits.

// File: rtl/lcd_clk_pkg.sv
package lcd_clk_pkg;

    localparam int BUS_W      = 8;
    localparam int PIX_DIV_W  = 6;
    localparam int ACD_RATE_W = 4;

    // byte offsets decoded by the register file
    localparam logic [BUS_W-1:0] OFS_ACD_RATE = 8'h23;
    localparam logic [BUS_W-1:0] OFS_PIX_DIV  = 8'h25;
    localparam logic [BUS_W-1:0] OFS_CTRL     = 8'h27;

    // control byte fields
    localparam int CTRL_EN_BIT    = 7;
    localparam int CTRL_BURST_BIT = 6;
    localparam int CTRL_SRC_BIT   = 0;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_ACD  = 2'd1,
        SEL_PIX  = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_e;

    typedef enum logic {
        SRC_PLL = 1'b0,
        SRC_ALT = 1'b1
    } clk_src_e;

    function automatic reg_sel_e decode_addr(input logic [BUS_W-1:0] addr);
        reg_sel_e sel;
        case (addr)
            OFS_ACD_RATE: sel = SEL_ACD;
            OFS_PIX_DIV:  sel = SEL_PIX;
            OFS_CTRL:     sel = SEL_CTRL;
            default:      sel = SEL_NONE;
        endcase
        return sel;
    endfunction

    function automatic logic pick_tick(input clk_src_e src, input logic t_pll,
                                       input logic t_alt);
        return (src == SRC_ALT) ? t_alt : t_pll;
    endfunction

endpackage

// File: rtl/lcd_cfg_regs.sv
module lcd_cfg_regs
    import lcd_clk_pkg::*;
#(
    parameter int DW     = BUS_W,
    parameter int DIV_W  = PIX_DIV_W,
    parameter int RATE_W = ACD_RATE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic [RATE_W-1:0] rate_cfg,
    output logic [DIV_W-1:0]  div_cfg,
    output logic [DW-1:0]     ctrl_cfg
);
    localparam int RATE_PAD = DW - RATE_W;
    localparam int DIV_PAD  = DW - DIV_W;

    reg_sel_e sel;

    always_comb sel = decode_addr(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_cfg <= '0;
            div_cfg  <= '0;
            ctrl_cfg <= '0;
        end else if (we) begin
            case (sel)
                SEL_ACD:  rate_cfg <= wdata[RATE_W-1:0];
                SEL_PIX:  div_cfg  <= wdata[DIV_W-1:0];
                SEL_CTRL: ctrl_cfg <= wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SEL_ACD:  rdata = {{RATE_PAD{1'b0}}, rate_cfg};
            SEL_PIX:  rdata = {{DIV_PAD{1'b0}}, div_cfg};
            SEL_CTRL: rdata = ctrl_cfg;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/lcd_pix_div.sv
module lcd_pix_div #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             tick,
    input  logic [DIV_W-1:0] div_cfg,
    output logic             pix_en
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] ratio_q;   // divider value in use for this period
    logic             wrap;

    // a zero ratio wraps on every tick, which is the bypass path
    always_comb wrap = (ratio_q == '0) || (cnt_q == ratio_q);
    always_comb pix_en = active && tick && wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            ratio_q <= '0;
        end else if (!active) begin
            cnt_q   <= '0;
            ratio_q <= div_cfg;
        end else if (tick) begin
            if (wrap) begin
                cnt_q   <= '0;
                ratio_q <= div_cfg;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/lcd_acd_gen.sv
module lcd_acd_gen #(
    parameter int RATE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              flm,
    input  logic [RATE_W-1:0] rate_cfg,
    output logic              acd
);
    logic [RATE_W-1:0] cnt_q;
    logic [RATE_W-1:0] rate_q;
    logic              acd_q;
    logic              wrap;

    always_comb wrap = (cnt_q == rate_q);
    always_comb acd = acd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            rate_q <= '0;
            acd_q  <= 1'b0;
        end else if (!active) begin
            cnt_q  <= '0;
            rate_q <= rate_cfg;
            acd_q  <= 1'b0;
        end else if (flm) begin
            if (wrap) begin
                cnt_q  <= '0;
                rate_q <= rate_cfg;
                acd_q  <= ~acd_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/lcd_clk_ctrl.sv
module lcd_clk_ctrl
    import lcd_clk_pkg::*;
#(
    parameter int DIV_W  = PIX_DIV_W,
    parameter int RATE_W = ACD_RATE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_we,
    input  logic [BUS_W-1:0] bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             pll_tick,
    input  logic             alt_tick,
    input  logic             flm_pulse,
    output logic             pix_en,
    output logic             acd,
    output logic             lcd_active,
    output logic             burst16
);
    logic [RATE_W-1:0] rate_cfg;
    logic [DIV_W-1:0]  div_cfg;
    logic [BUS_W-1:0]  ctrl_cfg;
    logic              active_q;
    logic              src_tick;
    clk_src_e          src_sel;

    lcd_cfg_regs #(
        .DW    (BUS_W),
        .DIV_W (DIV_W),
        .RATE_W(RATE_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (bus_we),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .rdata   (bus_rdata),
        .rate_cfg(rate_cfg),
        .div_cfg (div_cfg),
        .ctrl_cfg(ctrl_cfg)
    );

    // enable is sampled only on a frame marker, in both directions
    always_ff @(posedge clk) begin
        if (rst)            active_q <= 1'b0;
        else if (flm_pulse) active_q <= ctrl_cfg[CTRL_EN_BIT];
    end

    always_comb begin
        src_sel  = clk_src_e'(ctrl_cfg[CTRL_SRC_BIT]);
        src_tick = pick_tick(src_sel, pll_tick, alt_tick);
    end

    lcd_pix_div #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst    (rst),
        .active (active_q),
        .tick   (src_tick),
        .div_cfg(div_cfg),
        .pix_en (pix_en)
    );

    lcd_acd_gen #(.RATE_W(RATE_W)) u_acd (
        .clk     (clk),
        .rst     (rst),
        .active  (active_q),
        .flm     (flm_pulse),
        .rate_cfg(rate_cfg),
        .acd     (acd)
    );

    always_comb begin
        lcd_active = active_q;
        burst16    = ctrl_cfg[CTRL_BURST_BIT];
    end

endmodule

// File: rtl/lcd_clk_ctrl_chk.sv
module lcd_clk_ctrl_chk
    import lcd_clk_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             flm_pulse,
    input logic             lcd_active,
    input logic             pix_en,
    input logic             acd,
    input logic [BUS_W-1:0] bus_addr,
    input logic [BUS_W-1:0] bus_rdata
);
    AST_PIX_QUIET: assert property (@(posedge clk) disable iff (rst)
        !lcd_active |-> !pix_en); // R8

    AST_ACD_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (!lcd_active && $past(!lcd_active)) |-> !acd); // R8

    AST_EN_AT_FLM: assert property (@(posedge clk) disable iff (rst)
        !flm_pulse |=> $stable(lcd_active)); // R7

    AST_ACD_AT_FLM: assert property (@(posedge clk) disable iff (rst)
        (!flm_pulse && lcd_active) |=> $stable(acd)); // R6

    AST_RATE_MASK: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFS_ACD_RATE) |-> (bus_rdata[7:4] == 4'h0)); // R2

    AST_DIV_MASK: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFS_PIX_DIV) |-> (bus_rdata[7:6] == 2'b00)); // R2

endmodule

bind lcd_clk_ctrl lcd_clk_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .flm_pulse (flm_pulse),
    .lcd_active(lcd_active),
    .pix_en    (pix_en),
    .acd       (acd),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata)
);

// File: tb/sim_lcd_clk_ctrl.sv
module sim_lcd_clk_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_we = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       pll_tick = 1'b0;
    logic       alt_tick = 1'b0;
    logic       flm_pulse = 1'b0;
    logic       pix_en, acd, lcd_active, burst16;

    int n_checks = 0;
    int n_fail = 0;
    string pix_tag = "R3";
    bit done = 0;

    // reference state
    int         m_rate, m_div, m_dcnt, m_dact, m_acnt, m_aact;
    logic [7:0] m_ctrl;
    bit         m_active, m_acd;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_clk_ctrl u0 (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pll_tick(pll_tick),
        .alt_tick(alt_tick), .flm_pulse(flm_pulse), .pix_en(pix_en),
        .acd(acd), .lcd_active(lcd_active), .burst16(burst16)
    );

    function automatic bit ref_tick();
        return m_ctrl[0] ? alt_tick : pll_tick;
    endfunction

    // behavioural model advanced on each rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_rate = 0; m_div = 0; m_ctrl = 8'h00; m_active = 0; m_acd = 0;
            m_dcnt = 0; m_dact = 0; m_acnt = 0; m_aact = 0;
        end else begin
            if (!m_active) begin
                m_dcnt = 0; m_dact = m_div;
                m_acnt = 0; m_aact = m_rate; m_acd = 0;
            end else begin
                if (ref_tick()) begin
                    if (m_dact == 0 || m_dcnt == m_dact) begin
                        m_dcnt = 0; m_dact = m_div;
                    end else m_dcnt++;
                end
                if (flm_pulse) begin
                    if (m_acnt == m_aact) begin
                        m_acd = !m_acd; m_acnt = 0; m_aact = m_rate;
                    end else m_acnt++;
                end
            end
            if (flm_pulse) m_active = m_ctrl[7];
            if (bus_we) begin
                case (bus_addr)
                    8'h23: m_rate = int'(bus_wdata[3:0]);
                    8'h25: m_div = int'(bus_wdata[5:0]);
                    8'h27: m_ctrl = bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int ref_rdata();
        case (bus_addr)
            8'h23: return m_rate;
            8'h25: return m_div;
            8'h27: return int'(m_ctrl);
            default: return 0;
        endcase
    endfunction

    task automatic compare();
        bit exp_pix;
        exp_pix = m_active && ref_tick() && (m_dact == 0 || m_dcnt == m_dact);
        if (!rst) begin
            chk({pix_tag, " pix_en"}, int'(pix_en), int'(exp_pix));
            chk("R2 rdata", int'(bus_rdata), ref_rdata());
            chk("R6 acd", int'(acd), int'(m_acd));
            chk("R7 lcd_active", int'(lcd_active), int'(m_active));
            chk("R9 burst16", int'(burst16), int'(m_ctrl[6]));
        end
    endtask

    task automatic cyc(input bit we, input logic [7:0] a, input logic [7:0] d,
                       input bit tp, input bit ta, input bit f);
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = d;
        pll_tick = tp; alt_tick = ta; flm_pulse = f;
        #(CLK_PERIOD/4);
        compare();
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        cyc(1, a, d, 0, 0, 0);
    endtask

    task automatic rd(input string tag, input logic [7:0] a, input int exp);
        cyc(0, a, 8'h00, 0, 0, 0);
        chk(tag, int'(bus_rdata), exp);
    endtask

    task automatic run(input int n, input int p_pll, input int p_alt, input int flm_gap);
        for (int i = 0; i < n; i++) begin
            cyc(0, 8'h27, 8'h00, ($urandom % 100) < p_pll, ($urandom % 100) < p_alt,
                (i % flm_gap) == flm_gap - 1);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(17));
        for (int i = 0; i < 4; i++) cyc(0, 8'h00, 8'h00, 1, 1, 1);
        @(negedge clk); rst = 0;
        // R1: reset state
        rd("R1 rate reg", 8'h23, 0);
        rd("R1 div reg", 8'h25, 0);
        rd("R1 ctrl reg", 8'h27, 0);
        chk("R1 pix_en", int'(pix_en), 0);
        chk("R1 acd", int'(acd), 0);
        chk("R1 lcd_active", int'(lcd_active), 0);
        chk("R1 burst16", int'(burst16), 0);

        // R2: masking and unmapped address
        wr(8'h23, 8'hFF); rd("R2 rate mask", 8'h23, 8'h0F);
        wr(8'h25, 8'hFF); rd("R2 div mask", 8'h25, 8'h3F);
        wr(8'h24, 8'h55); rd("R2 unmapped", 8'h24, 0);
        rd("R2 rate untouched", 8'h23, 8'h0F);
        wr(8'h27, 8'h41); rd("R2 ctrl", 8'h27, 8'h41);
        chk("R9 burst16 set", int'(burst16), 1);

        // R7: enable waits for FLM
        wr(8'h23, 8'h02); wr(8'h25, 8'h03); wr(8'h27, 8'h80);
        for (int i = 0; i < 5; i++) cyc(0, 8'h27, 0, 1, 1, 0);
        chk("R7 no enable before flm", int'(lcd_active), 0);
        cyc(0, 8'h27, 0, 0, 0, 1);
        cyc(0, 8'h27, 0, 0, 0, 0);
        chk("R7 enable at flm", int'(lcd_active), 1);

        pix_tag = "R3"; run(800, 70, 30, 9);
        pix_tag = "R10"; wr(8'h25, 8'h05); wr(8'h23, 8'h04); run(600, 60, 30, 7);
        pix_tag = "R4"; wr(8'h25, 8'h00); run(300, 50, 50, 11);
        pix_tag = "R5"; wr(8'h27, 8'h81); run(200, 90, 20, 8);
        wr(8'h25, 8'h02); run(400, 10, 80, 8);
        pix_tag = "R6"; wr(8'h27, 8'hC0); wr(8'h23, 8'h00); run(300, 50, 50, 5);

        // R7 / R8: disable waits for FLM, then outputs go quiet
        wr(8'h27, 8'h00);
        for (int i = 0; i < 5; i++) cyc(0, 8'h27, 0, 1, 1, 0);
        chk("R7 disable waits for flm", int'(lcd_active), 1);
        cyc(0, 8'h27, 0, 1, 1, 1);
        cyc(0, 8'h27, 0, 1, 1, 0);
        cyc(0, 8'h27, 0, 1, 1, 0);
        chk("R8 pix_en idle", int'(pix_en), 0);
        chk("R8 acd idle", int'(acd), 0);
        pix_tag = "R8"; run(200, 80, 80, 6);

        pix_tag = "R3"; wr(8'h23, 8'h0F); wr(8'h25, 8'h3F); wr(8'h27, 8'h80);
        run(1500, 90, 10, 3);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule